// File: doc/BRIEF.md
# Call/Return Frame Sequencer

This block carries out the subroutine call and subroutine return steps of a stack machine. The machine keeps its top-of-stack value in a register (TS), apart from the stack memory. The surrounding core hands the block five values: the program counter, the frame pointer, the stack pointer, the cached top of stack and the instruction argument. It also gives a one-cycle start pulse and a flag that selects return instead of call. The sequencer then runs its accesses, one per cycle, on a single word-addressed memory port. When it finishes, it presents the updated register set together with a one-cycle done pulse.

A call first spills the cached top of stack to memory. It then reads the frame-size word at the call target and saves the caller's frame pointer into the new frame. It places the return address just above the saved pointer and resumes execution one word past the target. A return reloads the program counter and the frame pointer from the frame. It decides on its own whether a value is being returned: if SP equals FP, the stack is empty and it does a plain return that reloads TS from memory; otherwise it does a value-carrying return that keeps TS.

Top module: `frame_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first start, busy, done, mem_rd and mem_wr are 0 and the pc/fp/sp/ts outputs are 0.
- R2: A call begins by writing the incoming TS to address SP+1.
- R3: A call reads the word at address arg_in (the target). Its bits [AW+7:8] give the frame size k; all other bits of that word are ignored.
- R4: A call writes the old FP to address FP+k and then writes PC+1 to address FP+k+1. It finishes with fp_out=FP+k, sp_out=FP+k+1, pc_out=target+1 and ts_out=PC+1, zero-extended.
- R5: A return sets pc_out to the low AW bits of the word at FP+1.
- R6: When SP equals FP at a return, it is a plain return. ts_out becomes the word at FP-arg, sp_out becomes FP-arg-1, and fp_out becomes the low AW bits of the word at FP.
- R7: When SP differs from FP at a return, it is a value return. ts_out keeps the incoming TS, sp_out becomes FP-arg, and fp_out becomes the low AW bits of the word at FP. No return ever writes memory.
- R8: Each cycle makes at most one memory access, and done is high for exactly one cycle. Counted in clock edges after the edge that accepts start, done appears after 4 edges for a call, 3 for a plain return and 2 for a value return. Results then hold until the next start.
- R9: A start that arrives while busy is high is ignored: the running operation's results and its single done pulse are unchanged.
- R10: All address arithmetic wraps modulo 2^AW, and no frame bounds are checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| is_ret | input | 1 | 1 selects return, 0 selects call |
| pc_in | input | AW | Current program counter |
| fp_in | input | AW | Current frame pointer |
| sp_in | input | AW | Current stack pointer |
| ts_in | input | DW | Cached top of stack |
| arg_in | input | AW | Call target, or return pop count |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Read strobe; data sampled at the cycle's end |
| mem_wr | output | 1 | Write strobe; written at the cycle's end |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the same cycle as mem_rd |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | AW | Updated program counter |
| fp_out | output | AW | Updated frame pointer |
| sp_out | output | AW | Updated stack pointer |
| ts_out | output | DW | Updated top of stack |

## Verification
Suppose the sequencer goes down the wrong branch at a return, or reads the frame size from the wrong bits. That error shows at the done pulse, within four cycles of start: a wrong sp_out or ts_out, or a done pulse one cycle early or late. An address error in a call shows as a spilled word, saved pointer or return address landing in the wrong memory cell, which the bench inspects right after done. A sequencer stuck outside its idle state shows as busy staying high and done never arriving.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int KLSB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_ret,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] fp_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] ts_in,
  input  logic [AW-1:0] arg_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] fp_out,
  output logic [AW-1:0] sp_out,
  output logic [DW-1:0] ts_out
);

  typedef enum logic [2:0] {
    S_IDLE, S_SPILL, S_SIZE, S_LINK, S_RADDR, S_RPC, S_RPOP, S_RFP
  } st_t;

  st_t           st;
  logic [AW-1:0] pc_q, fp_q, sp_q, arg_q, tgt_q, k_q;
  logic [DW-1:0] ts_q;
  logic          done_q;

  logic [AW-1:0] pc_inc, sp_inc, fp_k, fp_arg;
  assign pc_inc = pc_q + AW'(1);
  assign sp_inc = sp_q + AW'(1);
  assign fp_k   = fp_q + k_q;
  assign fp_arg = fp_q - arg_q;

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = ts_q;
    unique case (st)
      S_SPILL: begin mem_addr = sp_inc;          mem_wr = 1'b1; end
      S_SIZE:  begin mem_addr = tgt_q;           mem_rd = 1'b1; end
      S_LINK:  begin mem_addr = fp_k;            mem_wr = 1'b1;
                     mem_wdata = {{(DW-AW){1'b0}}, fp_q}; end
      S_RADDR: begin mem_addr = sp_inc;          mem_wr = 1'b1; end
      S_RPC:   begin mem_addr = fp_q + AW'(1);   mem_rd = 1'b1; end
      S_RPOP:  begin mem_addr = fp_arg;          mem_rd = 1'b1; end
      S_RFP:   begin mem_addr = fp_q;            mem_rd = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pc_q   <= '0;
      fp_q   <= '0;
      sp_q   <= '0;
      ts_q   <= '0;
      arg_q  <= '0;
      tgt_q  <= '0;
      k_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          pc_q  <= pc_in;
          fp_q  <= fp_in;
          sp_q  <= sp_in;
          ts_q  <= ts_in;
          arg_q <= arg_in;
          st    <= is_ret ? S_RPC : S_SPILL;
        end
        S_SPILL: begin
          sp_q  <= sp_inc;
          ts_q  <= {{(DW-AW){1'b0}}, pc_inc};
          tgt_q <= arg_q;
          st    <= S_SIZE;
        end
        S_SIZE: begin
          k_q <= mem_rdata[KLSB +: AW];
          st  <= S_LINK;
        end
        S_LINK: begin
          fp_q <= fp_k;
          sp_q <= fp_k;
          st   <= S_RADDR;
        end
        S_RADDR: begin
          sp_q   <= sp_inc;
          pc_q   <= tgt_q + AW'(1);
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        S_RPC: begin
          pc_q <= mem_rdata[AW-1:0];
          if (sp_q == fp_q) begin
            st <= S_RPOP;
          end else begin
            sp_q <= fp_arg;
            st   <= S_RFP;
          end
        end
        S_RPOP: begin
          ts_q <= mem_rdata;
          sp_q <= fp_arg - AW'(1);
          st   <= S_RFP;
        end
        S_RFP: begin
          fp_q   <= mem_rdata[AW-1:0];
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign pc_out = pc_q;
  assign fp_out = fp_q;
  assign sp_out = sp_q;
  assign ts_out = ts_q;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          is_ret,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] pc_out,
  input logic [AW-1:0] fp_out,
  input logic [AW-1:0] sp_out
);

  logic was_call;
  always_ff @(posedge clk) begin
    if (!rst_n)              was_call <= 1'b0;
    else if (start && !busy) was_call <= !is_ret;
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_rd && !mem_wr)); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R8
  AST_CALL_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (done && was_call) |-> (sp_out == fp_out + AW'(1))); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pc_out) && $stable(fp_out) && $stable(sp_out))); // R8

endmodule

bind frame_seq frame_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .is_ret(is_ret),
  .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .pc_out(pc_out), .fp_out(fp_out), .sp_out(sp_out)
);

// File: tb/test_frame_seq.sv
`timescale 1ns/1ps
module test_frame_seq;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_ret = 1'b0;
  logic [AW-1:0] pc_in = '0, fp_in = '0, sp_in = '0, arg_in = '0;
  logic [DW-1:0] ts_in = '0;
  logic [AW-1:0] mem_addr, pc_out, fp_out, sp_out;
  logic mem_rd, mem_wr, busy, done;
  logic [DW-1:0] mem_wdata, mem_rdata, ts_out;

  logic [DW-1:0] mem [1<<AW];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  always #10 clk = ~clk;

  frame_seq #(.AW(AW), .DW(DW)) i_frame_seq (.*);

  int n_chk = 0, n_bad = 0;
  int lat, rds, wrs;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // word(i) = {C0, ~i, i[7:4]+1, i+0x11}; frame size field is bits [15:8]
  task automatic fill();
    for (int i = 0; i < (1 << AW); i++) begin
      logic [7:0] b;
      b = 8'(i);
      mem[i] = {8'hC0, ~b, {4'h0, b[7:4]} + 8'd1, b + 8'h11};
    end
  endtask

  task automatic launch(input logic r, input logic [7:0] pc, fp, sp,
                        input logic [31:0] ts, input logic [7:0] arg);
    @(negedge clk);
    is_ret = r; pc_in = pc; fp_in = fp; sp_in = sp; ts_in = ts; arg_in = arg;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    lat = 0; rds = 0; wrs = 0;
    while (!done && lat < 20) begin
      if (mem_rd) rds++;
      if (mem_wr) wrs++;
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  typedef struct packed {
    logic        r;
    logic [7:0]  pc, fp, sp;
    logic [31:0] ts;
    logic [7:0]  arg, epc, efp, esp;
    logic [31:0] ets;
    logic [3:0]  elat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h10, 8'h40, 8'h45, 32'hDEADBEEF, 8'h80, 8'h81, 8'h49, 8'h4A, 32'h00000011, 4'd4},
    '{1'b0, 8'hFF, 8'hFD, 8'hFE, 32'h12345678, 8'h35, 8'h36, 8'h01, 8'h02, 32'h00000000, 4'd4},
    '{1'b0, 8'h20, 8'h10, 8'h18, 32'hCAFE0001, 8'hF0, 8'hF1, 8'h20, 8'h21, 32'h00000021, 4'd4},
    '{1'b1, 8'h33, 8'h60, 8'h60, 32'h0000AAAA, 8'h03, 8'h72, 8'h71, 8'h5C, 32'hC0A2066E, 4'd3},
    '{1'b1, 8'h33, 8'h60, 8'h63, 32'h0BADF00D, 8'h02, 8'h72, 8'h71, 8'h5E, 32'h0BADF00D, 4'd2},
    '{1'b1, 8'h44, 8'h01, 8'h01, 32'h55555555, 8'h04, 8'h13, 8'h12, 8'hFC, 32'hC002100E, 4'd3},
    '{1'b1, 8'h44, 8'hFF, 8'h05, 32'h77777777, 8'h00, 8'h11, 8'h10, 8'hFF, 32'h77777777, 4'd2}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 no access in reset", {mem_rd, mem_wr}, 0);
    check("R1 outputs zero", {pc_out, fp_out, sp_out, ts_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {busy, done, mem_rd, mem_wr}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = TBL[v];
      fill();
      launch(t.r, t.pc, t.fp, t.sp, t.ts, t.arg);
      wait_done();
      check(t.r ? "R5 pc" : "R4 pc", pc_out, t.epc);
      check(t.r ? "R6/R7 fp" : "R4 fp", fp_out, t.efp);
      check(t.r ? "R6/R7 sp R10" : "R4 sp R10", sp_out, t.esp);
      check(t.r ? "R6/R7 ts" : "R4 ts", ts_out, t.ets);
      check("R8 latency", lat, t.elat);
      check("R8 writes", wrs, t.r ? 0 : 3);
      check("R3/R8 reads", rds, t.r ? t.elat : 1);
      if (!t.r) begin
        check("R2 spill", mem[8'(t.sp + 8'd1)], t.ts);
        check("R4 saved fp", mem[t.efp], {24'h0, t.fp});
        check("R4 return addr", mem[t.esp], t.ets);
      end
      @(negedge clk);
      check("R8 done one cycle", done, 0);
      check("R8 results held", {pc_out, fp_out, sp_out, ts_out}, {t.epc, t.efp, t.esp, t.ets});
    end

    // R9: start pulses during a running call are ignored
    begin
      int dones;
      fill();
      launch(1'b0, 8'h10, 8'h40, 8'h45, 32'hDEADBEEF, 8'h80);
      is_ret = 1'b1; pc_in = 8'h99; fp_in = 8'h11; sp_in = 8'h11; arg_in = 8'h01;
      start = 1'b1;
      dones = 0;
      for (int c = 0; c < 3; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (done) dones++;
      end
      start = 1'b0;
      for (int c = 0; c < 8; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (done) dones++;
      end
      check("R9 single done", dones, 1);
      check("R9 result unchanged", {pc_out, fp_out, sp_out, ts_out},
            {8'h81, 8'h49, 8'h4A, 32'h00000011});
      check("R9 idle", busy, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule